// File: doc/BRIEF.md
# Hardware Barrier Synchronization Unit

This block gathers a set of agents at a common meeting point. Each of the `NUM_AGENTS` agents signals with a one-cycle pulse on its bit of `arrive_i` that it has reached the barrier. The unit remembers which agents are already waiting and keeps a count of the agents still missing. That count starts at `NUM_AGENTS` and goes down by the number of new arrivals in each cycle. When the arrivals of a cycle bring the missing count to zero, every agent is let go at once. A one-cycle pulse appears on all bits of `release_o`, the missing count reloads, and the phase bit flips. The barrier is then ready for the next round.

Control is a three-state machine. **EMPTY** means no agent waits. **GATHER** means at least one agent waits and some are still missing. **FIRE** is the single release cycle. The transitions are as follows. EMPTY→GATHER and GATHER→GATHER happen when new arrivals leave agents missing. EMPTY→FIRE and GATHER→FIRE happen when the arrivals complete the set. GATHER→EMPTY happens only through reset. From FIRE the machine moves to EMPTY when nobody arrives, to GATHER when some agents arrive, and back to FIRE when all agents arrive in that cycle. Arrivals seen in the FIRE cycle count toward the next phase. If an agent pulses `arrive_i` again while it already waits, the pulse is dropped and that agent's `dup_err_o` bit is raised in the following cycle.

Top module: `barrier_sync_unit`

## Requirements
- R1: A synchronous active-high `rst` drives `release_o` to all zeros, `phase_o` to 0 and `dup_err_o` to all zeros. It clears every waiting agent and loads the missing count with `NUM_AGENTS`, including when reset comes in the middle of a gather.
- R2: `release_o` stays all zeros as long as at least one agent has not arrived in the current phase.
- R3: In the cycle after the clock edge that captures the final missing arrival, every bit of `release_o` is 1. It is 1 for exactly one cycle. `release_o` is never a mix of ones and zeros.
- R4: Several distinct agents arriving in the same cycle each reduce the missing count by one.
- R5: `phase_o` inverts in the same cycle that `release_o` is high, and changes at no other time.
- R6: On release the missing count returns to `NUM_AGENTS`. An arrival presented in the release cycle counts toward the next phase.
- R7: An arrive pulse from an agent already waiting in the current phase does not change the missing count. The matching bit of `dup_err_o` (bit i for agent i) is 1 in the next cycle.
- R8: If all agents arrive in a single cycle, whether from an empty barrier or during a release cycle, a release follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| arrive_i | input | NUM_AGENTS | Per-agent arrival pulse, bit i belongs to agent i |
| release_o | output | NUM_AGENTS | Per-agent release pulse, all bits high together for one cycle |
| phase_o | output | 1 | Barrier phase, inverts on each release |
| dup_err_o | output | NUM_AGENTS | Per-agent flag for a dropped repeated arrival, one cycle |

## Verification
Some properties are checked by assertions on every cycle. The missing count always stays between one and `NUM_AGENTS`, and it always adds up with the set of waiting agents to the full agent count. `release_o` is always uniform. A completed set is always followed by FIRE. The phase flips exactly with release. No duplicate flag can appear while nobody waits. Other behaviours can only be shown by the bench's sequences. These are the exact cycle in which release appears, the way same-cycle and repeated arrivals change the moment of release, arrivals counted during a release cycle, and a reset taken halfway through a gather.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_GATHER = 2'd1,
        ST_FIRE   = 2'd2
    } bar_state_e;
endpackage

// File: rtl/barrier_arrive_filter.sv
module barrier_arrive_filter #(
    parameter int NUM_AGENTS = 4,
    parameter int CW         = $clog2(NUM_AGENTS + 1)
) (
    input  logic [NUM_AGENTS-1:0] arrive_i,
    input  logic [NUM_AGENTS-1:0] waiting_i,
    output logic [NUM_AGENTS-1:0] accept_o,
    output logic [NUM_AGENTS-1:0] dup_o,
    output logic [CW-1:0]         take_o
);
    always_comb begin
        accept_o = arrive_i & ~waiting_i;
        dup_o    = arrive_i & waiting_i;
        take_o   = '0;
        for (int i = 0; i < NUM_AGENTS; i++) begin
            take_o = take_o + CW'(accept_o[i]);
        end
    end
endmodule

// File: rtl/barrier_count.sv
module barrier_count #(
    parameter int NUM_AGENTS = 4,
    parameter int CW         = $clog2(NUM_AGENTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] take_i,
    output logic [CW-1:0] count_o,
    output logic          hit_o
);
    localparam logic [CW-1:0] FULL = CW'(NUM_AGENTS);

    logic [CW-1:0] count_q;

    assign count_o = count_q;
    assign hit_o   = (take_i == count_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= FULL;
        end else if (hit_o) begin
            count_q <= FULL;
        end else begin
            count_q <= count_q - take_i;
        end
    end

    // R6: the missing count never leaves the range 1..NUM_AGENTS
    assert_count_range_R6: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0) && (count_q <= FULL));

    // R4: arrivals never take more than are missing
    assert_take_bound_R4: assert property (@(posedge clk) disable iff (rst)
        take_i <= count_q);
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit
    import barrier_pkg::*;
#(
    parameter int NUM_AGENTS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_AGENTS-1:0] arrive_i,
    output logic [NUM_AGENTS-1:0] release_o,
    output logic                  phase_o,
    output logic [NUM_AGENTS-1:0] dup_err_o
);
    localparam int CW = $clog2(NUM_AGENTS + 1);

    bar_state_e            state_q, state_d;
    logic                  phase_q;
    logic [NUM_AGENTS-1:0] waiting_q, waiting_d;
    logic [NUM_AGENTS-1:0] dup_q;
    logic [NUM_AGENTS-1:0] accept;
    logic [NUM_AGENTS-1:0] dup;
    logic [CW-1:0]         take;
    logic [CW-1:0]         missing;
    logic                  complete;

    barrier_arrive_filter #(.NUM_AGENTS(NUM_AGENTS), .CW(CW)) filter_i (
        .arrive_i  (arrive_i),
        .waiting_i (waiting_q),
        .accept_o  (accept),
        .dup_o     (dup),
        .take_o    (take)
    );

    barrier_count #(.NUM_AGENTS(NUM_AGENTS), .CW(CW)) count_i (
        .clk     (clk),
        .rst     (rst),
        .take_i  (take),
        .count_o (missing),
        .hit_o   (complete)
    );

    // next-state logic
    always_comb begin
        waiting_d = waiting_q | accept;
        state_d   = state_q;
        unique case (state_q)
            ST_EMPTY, ST_GATHER, ST_FIRE: begin
                if (complete) begin
                    state_d   = ST_FIRE;
                    waiting_d = '0;
                end else if (waiting_d != '0) begin
                    state_d = ST_GATHER;
                end else begin
                    state_d = ST_EMPTY;
                end
            end
            default: begin
                state_d   = ST_EMPTY;
                waiting_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_EMPTY;
            waiting_q <= '0;
            phase_q   <= 1'b0;
            dup_q     <= '0;
        end else begin
            state_q   <= state_d;
            waiting_q <= waiting_d;
            dup_q     <= dup;
            if (complete) begin
                phase_q <= ~phase_q;
            end
        end
    end

    // outputs
    always_comb begin
        release_o = {NUM_AGENTS{state_q == ST_FIRE}};
        phase_o   = phase_q;
        dup_err_o = dup_q;
    end

    // R3: release is all-or-nothing
    assert_release_uniform_R3: assert property (@(posedge clk) disable iff (rst)
        (release_o == '0) || (release_o == '1));

    // R3: a completed set is released on the next cycle
    assert_complete_fires_R3: assert property (@(posedge clk) disable iff (rst)
        complete |=> (release_o == '1));

    // R5: phase flips exactly when release is shown
    assert_phase_flip_R5: assert property (@(posedge clk) disable iff (rst)
        complete |=> (phase_o != $past(phase_o)));
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !complete |=> $stable(phase_o));

    // R4: waiting agents and missing count always add up to the full set
    assert_count_balance_R4: assert property (@(posedge clk) disable iff (rst)
        ($countones(waiting_q) + int'(missing)) == NUM_AGENTS);

    // R7: no duplicate can be flagged when nobody was waiting
    assert_no_dup_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_GATHER) |=> (dup_err_o == '0));
endmodule

// File: tb/barrier_sync_unit_tb_top.sv
module barrier_sync_unit_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] arrive;
    logic [N-1:0] release_w;
    logic         phase_w;
    logic [N-1:0] dup_w;

    int tests  = 0;
    int failed = 0;

    always #4 clk = ~clk;  // 125 MHz

    barrier_sync_unit #(.NUM_AGENTS(N)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .arrive_i  (arrive),
        .release_o (release_w),
        .phase_o   (phase_w),
        .dup_err_o (dup_w)
    );

    // vector: {arrive[3:0], expect_release, expect_phase, expect_dup[3:0]}
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        {4'b0001, 1'b0, 1'b0, 4'b0000},  // first arrival (R2)
        {4'b0010, 1'b0, 1'b0, 4'b0000},
        {4'b0001, 1'b0, 1'b0, 4'b0001},  // repeat ignored (R7)
        {4'b0000, 1'b0, 1'b0, 4'b0000},
        {4'b1100, 1'b1, 1'b1, 4'b0000},  // two at once complete (R4 R3)
        {4'b0011, 1'b0, 1'b1, 4'b0000},  // arrive in FIRE cycle (R6)
        {4'b0001, 1'b0, 1'b1, 4'b0001},  // repeat in new phase (R7)
        {4'b1100, 1'b1, 1'b0, 4'b0000},  // completes phase 2 (R6)
        {4'b1111, 1'b1, 1'b1, 4'b0000},  // all at once during FIRE (R8)
        {4'b0000, 1'b0, 1'b1, 4'b0000},
        {4'b1010, 1'b0, 1'b1, 4'b0000},
        {4'b0110, 1'b0, 1'b1, 4'b0010},  // mixed repeat and new (R7 R4)
        {4'b0001, 1'b1, 1'b0, 4'b0000},
        {4'b0000, 1'b0, 1'b0, 4'b0000}
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] a);
        arrive = a;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        failed++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin : main
        rst    = 1'b1;
        arrive = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 release after reset", release_w, '0);
        check("R1 phase after reset", {3'b000, phase_w}, '0);
        check("R1 dup after reset", dup_w, '0);

        for (int k = 0; k < NV; k++) begin
            step(VEC[k][9:6]);
            check($sformatf("R2/R3/R4/R6/R8 release vec %0d", k), release_w,
                  {N{VEC[k][5]}});
            check($sformatf("R5 phase vec %0d", k), {3'b000, phase_w},
                  {3'b000, VEC[k][4]});
            check($sformatf("R7 dup vec %0d", k), dup_w, VEC[k][3:0]);
        end

        // R3: release lasts one cycle only (last vector already idle)
        check("R3 release single cycle", release_w, '0);

        // R8: all at once from an empty barrier
        step(4'b1111);
        check("R8 release from empty", release_w, '1);
        check("R5 phase flip on R8", {3'b000, phase_w}, 4'b0001);
        step(4'b0000);
        check("R3 release drops", release_w, '0);

        // R1: reset in the middle of a gather
        step(4'b0111);
        check("R2 no release with one missing", release_w, '0);
        rst = 1'b1;
        step(4'b0000);
        rst = 1'b0;
        check("R1 phase cleared by mid reset", {3'b000, phase_w}, '0);
        step(4'b1000);
        check("R1 count reloaded, no release", release_w, '0);
        step(4'b0100);
        check("R1 waiting cleared, no dup", dup_w, '0);
        step(4'b0011);
        check("R1 release after full set", release_w, '1);
        check("R5 phase after post-reset release", {3'b000, phase_w}, 4'b0001);

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule